// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block is a small bank of event counters that sits beside a memory controller and measures its activity. Slot 0 always counts clock cycles. Slots 1 and above each count one kind of controller event, picked by an 8-bit code held in that slot's control word. The controller presents at most one event per clock as a valid strobe plus a code. Every enabled event slot whose selector equals that code adds one on the same edge.

The cycle slot acts as the master of the bank. Event slots advance only while the cycle slot is enabled and has not overflowed. When the cycle slot wraps, it sets a sticky overflow flag, freezes every slot and raises the interrupt. Software reloads the cycle slot with a write of 0 and then a write of 1 to its clear bit. Each clear loads an 8-bit preload value into a fixed byte of the count, which shortens the time to the next overflow. An event slot is cleared by writing 0 to its clear bit. Its overflow raises no interrupt. A build parameter chooses whether an overflowed event slot keeps wrapping or parks at its maximum value.

Top module: `mc_perf_bank`

## Requirements
- R1: After reset every count is 0, the interrupt is low, slot 0's control word reads 0x00000000, and control words of slots 1..NUM_CTR-1 read 0x00000002 (only the clear bit set).
- R2: Control words are at byte address 4*i and counts at 0x20+4*i. Control layout: bit 0 overflow (read-only), bit 1 clear, bit 2 enable, bits 23:16 preload, bits 31:24 event selector, other bits 0. Writes to the count window are ignored. Unaligned or unmapped reads return 0. Slot 0's selector always reads 0.
- R3: While slot 0 is enabled and not overflowed, and its control word is not being written, its count rises by exactly 1 per clock.
- R4: Slot 0 is cleared only by a write with the clear bit 1 when the stored clear bit is 0. A write with clear 0 leaves its count unchanged, and so does a write with clear 1 when the stored bit is already 1.
- R5: A write with clear bit 0 to an event slot clears its count and overflow flag. The slot's clear bit always reads back 1, and a write with clear 1 leaves the count unchanged.
- R6: Every clear loads the count with the written preload value at bits PRE_LSB+7:PRE_LSB and zeros elsewhere.
- R7: An event slot adds 1 on a clock where ev_valid is high, ev_code equals its nonzero selector, it is enabled and the bank runs. Selector 0 never counts, and counts per slot are independent.
- R8: When slot 0 passes its maximum value it wraps to 0 and sets its overflow flag. It then holds all slots frozen until it is cleared.
- R9: irq is high exactly when slot 0's overflow flag and enable bit are both set.
- R10: An event slot passing its maximum sets its sticky overflow flag without raising irq. With EV_WRAP=1 it wraps and keeps counting. With EV_WRAP=0 it stays at all-ones until cleared.
- R11: While slot 0's enable bit is 0, no event slot changes, except through its own control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| ev_valid | input | 1 | An event is present this clock |
| ev_code | input | 8 | Code of the present event |
| irq | output | 1 | Cycle-slot overflow interrupt |

## Verification
The step and freeze properties apply only on clocks with no register write, because a control write takes priority over counting for the slot it targets. The stimulus therefore separates writes from the windows in which counting is measured. It drives at most one event code per clock, as the port requires. Overflow of the cycle slot is reached through preload rather than by running for a full period, using a 16-bit count with the preload byte at bit 8. This keeps the cycle slot well clear of overflow while the event-code sweeps run.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int CODE_W    = 8;
    localparam int CTRL_WORD0 = 0;   // word index of slot 0 control word
    localparam int CNT_WORD0  = 8;   // word index of slot 0 count (byte 0x20)

    // Control word, MSB first: selector, preload, reserved, enable, clear, overflow
    typedef struct packed {
        logic [CODE_W-1:0] sel;
        logic [7:0]        cp;
        logic [12:0]       rsvd;
        logic              en;
        logic              clr;
        logic              ovf;
    } ctrl_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_CTRL = 2'd1,
        WIN_CNT  = 2'd2
    } win_e;

    typedef struct packed {
        win_e              win;
        logic [ADDR_W-3:0] idx;
    } dec_t;

    function automatic dec_t addr_decode(input logic [ADDR_W-1:0] a, input int n);
        dec_t d;
        int   w;
        w     = int'(a[ADDR_W-1:2]);
        d.win = WIN_NONE;
        d.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (w >= CTRL_WORD0 && w < CTRL_WORD0 + n) begin
                d.win = WIN_CTRL;
                d.idx = (ADDR_W-2)'(w - CTRL_WORD0);
            end else if (w >= CNT_WORD0 && w < CNT_WORD0 + n) begin
                d.win = WIN_CNT;
                d.idx = (ADDR_W-2)'(w - CNT_WORD0);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mcpc_regif.sv
module mcpc_regif
    import mcpc_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  ctrl_t                         ctrl_q [NUM_CTR],
    input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q,
    output logic [NUM_CTR-1:0]            ctrl_we,
    output ctrl_t                         wr_ctrl,
    output logic [REG_W-1:0]              rd_data
);

    dec_t wdec;
    dec_t rdec;

    assign wr_ctrl = ctrl_t'(wr_data);

    // write strobes: only the control window is writable
    always_comb begin
        wdec    = addr_decode(wr_addr, NUM_CTR);
        ctrl_we = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            ctrl_we[i] = wr_en && (wdec.win == WIN_CTRL) && (int'(wdec.idx) == i);
        end
    end

    // read mux
    always_comb begin
        rdec    = addr_decode(rd_addr, NUM_CTR);
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rdec.win == WIN_CTRL && int'(rdec.idx) == i) rd_data = ctrl_q[i];
            if (rdec.win == WIN_CNT  && int'(rdec.idx) == i) rd_data = REG_W'(cnt_q[i]);
        end
    end

endmodule

// File: rtl/mcpc_counter.sv
module mcpc_counter
    import mcpc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int PRE_LSB  = 16,
    parameter bit IS_CYCLE = 1'b0,
    parameter bit EV_WRAP  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  ctrl_t            wr_ctrl,
    input  logic             step,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cnt_q
);

    localparam bit KEEP_MAX = !IS_CYCLE && !EV_WRAP;
    localparam bit RST_CLR  = !IS_CYCLE;

    logic              en_q;
    logic              clr_q;
    logic              ovf_q;
    logic [7:0]        cp_q;
    logic [CODE_W-1:0] sel_q;
    logic              clear_req;
    logic              halt_on_ovf;
    logic              inc;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  pre_val;
    logic              unused_wr;

    generate
        if (IS_CYCLE) begin : g_cyc
            // reload only on a 0 -> 1 transition of the stored clear bit
            assign clear_req   = ctrl_we && !clr_q && wr_ctrl.clr;
            assign halt_on_ovf = 1'b1;
        end else begin : g_evt
            // writing 0 requests the clear; the bit reads back as 1
            assign clear_req   = ctrl_we && !wr_ctrl.clr;
            assign halt_on_ovf = !EV_WRAP;
        end
    endgenerate

    assign inc       = step && en_q && !(halt_on_ovf && ovf_q);
    assign sum       = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign pre_val   = CNT_W'(wr_ctrl.cp) << PRE_LSB;
    assign unused_wr = ^{wr_ctrl.rsvd, wr_ctrl.ovf, wr_ctrl.sel};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            clr_q <= RST_CLR;
            ovf_q <= 1'b0;
            cp_q  <= '0;
            sel_q <= '0;
            cnt_q <= '0;
        end else if (ctrl_we) begin
            en_q  <= wr_ctrl.en;
            cp_q  <= wr_ctrl.cp;
            sel_q <= IS_CYCLE ? '0 : wr_ctrl.sel;
            clr_q <= IS_CYCLE ? wr_ctrl.clr : 1'b1;
            if (clear_req) begin
                cnt_q <= pre_val;
                ovf_q <= 1'b0;
            end
        end else if (inc) begin
            if (sum[CNT_W]) begin
                ovf_q <= 1'b1;
                if (!KEEP_MAX) cnt_q <= sum[CNT_W-1:0];
            end else begin
                cnt_q <= sum[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        ctrl_q      = '0;
        ctrl_q.sel  = sel_q;
        ctrl_q.cp   = cp_q;
        ctrl_q.en   = en_q;
        ctrl_q.clr  = clr_q;
        ctrl_q.ovf  = ovf_q;
    end

endmodule

// File: rtl/mc_perf_bank.sv
module mc_perf_bank
    import mcpc_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32,
    parameter int PRE_LSB = 16,
    parameter bit EV_WRAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ev_valid,
    input  logic [7:0]        ev_code,
    output logic              irq
);

    ctrl_t                         ctrl_q [NUM_CTR];
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CTR-1:0]            ctrl_we;
    logic [NUM_CTR-1:0]            step;
    logic [NUM_CTR-1:0]            ovf_v;
    ctrl_t                         wr_ctrl;
    logic                          run;

    mcpc_regif #(
        .NUM_CTR (NUM_CTR),
        .CNT_W   (CNT_W)
    ) u_regif (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .ctrl_q  (ctrl_q),
        .cnt_q   (cnt_q),
        .ctrl_we (ctrl_we),
        .wr_ctrl (wr_ctrl),
        .rd_data (rd_data)
    );

    assign run = ctrl_q[0].en && !ovf_v[0];
    assign irq = ovf_v[0] && ctrl_q[0].en;

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
            assign ovf_v[i] = ctrl_q[i].ovf;
            if (i == 0) begin : g_step_cyc
                assign step[i] = run;
            end else begin : g_step_evt
                assign step[i] = run && ev_valid && (ctrl_q[i].sel != '0)
                                 && (ev_code == ctrl_q[i].sel);
            end
            mcpc_counter #(
                .CNT_W    (CNT_W),
                .PRE_LSB  (PRE_LSB),
                .IS_CYCLE (i == 0),
                .EV_WRAP  (EV_WRAP)
            ) u_ctr (
                .clk     (clk),
                .rst     (rst),
                .ctrl_we (ctrl_we[i]),
                .wr_ctrl (wr_ctrl),
                .step    (step[i]),
                .ctrl_q  (ctrl_q[i]),
                .cnt_q   (cnt_q[i])
            );
        end
    endgenerate

endmodule

// File: rtl/mc_perf_bank_chk.sv
module mc_perf_bank_chk #(
    parameter int NUM_CTR = 4,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic                          run,
    input logic                          irq,
    input logic [NUM_CTR-1:0]            ovf_v,
    input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q
);

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_en) |=> (cnt_q[0] == CNT_W'($past(cnt_q[0]) + CNT_W'(1)))); // R3

    AST_CYC_OVF_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ovf_v[0] && !wr_en) |=> $stable(cnt_q[0])); // R8

    AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(wr_en)) |-> (cnt_q[0] == '0)); // R8

    generate
        for (genvar i = 1; i < NUM_CTR; i++) begin : g_evt
            AST_EVT_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> ((cnt_q[i] == $past(cnt_q[i])) ||
                            (cnt_q[i] == CNT_W'($past(cnt_q[i]) + CNT_W'(1))))); // R7

            AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
                (!run && !wr_en) |=> $stable(cnt_q[i])); // R11

            AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
                (ovf_v[i] && !wr_en) |=> ovf_v[i]); // R10
        end
    endgenerate

endmodule

bind mc_perf_bank mc_perf_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CNT_W   (CNT_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .run   (run),
    .irq   (irq),
    .ovf_v (ovf_v),
    .cnt_q (cnt_q)
);

// File: tb/mc_perf_bank_tb.sv
module mc_perf_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic [7:0]  rd_addr;
    logic        ev_valid;
    logic [7:0]  ev_code;
    logic [31:0] rd_w, rd_h;
    logic        irq_w, irq_h;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_perf_bank #(.NUM_CTR(NC), .CNT_W(16), .PRE_LSB(8), .EV_WRAP(1'b1)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_w), .ev_valid(ev_valid), .ev_code(ev_code),
        .irq(irq_w));

    mc_perf_bank #(.NUM_CTR(NC), .CNT_W(16), .PRE_LSB(8), .EV_WRAP(1'b0)) u_dut_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_h), .ev_valid(ev_valid), .ev_code(ev_code),
        .irq(irq_h));

    function automatic logic [31:0] cw(input logic [7:0] sel, input logic [7:0] cp,
                                       input logic en, input logic clr);
        return {sel, cp, 13'd0, en, clr, 1'b0};
    endfunction

    function automatic logic [7:0] ctl_a(input int i);
        return 8'(4 * i);
    endfunction

    function automatic logic [7:0] cnt_a(input int i);
        return 8'(8'h20 + 4 * i);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] code);
        ev_valid = 1'b1; ev_code = code;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_both(input string req, input string what, input logic [7:0] a,
                           input logic [31:0] exp_w, input logic [31:0] exp_h);
        rd_addr = a;
        #1;
        check(req, {what, " wrap"}, rd_w, exp_w);
        check(req, {what, " hold"}, rd_h, exp_h);
    endtask

    task automatic rd_same(input string req, input string what, input logic [7:0] a,
                           input logic [31:0] exp);
        rd_both(req, what, a, exp, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        #1;
        check(req, "irq wrap", {31'd0, irq_w}, {31'd0, exp});
        check(req, "irq hold", {31'd0, irq_h}, {31'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rep[256];
        int e2, e3;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; ev_valid = 1'b0; ev_code = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_same("R1", "ctrl0", ctl_a(0), 32'h0);
        for (int i = 1; i < NC; i++) rd_same("R1", "ctrlN", ctl_a(i), 32'h2);
        for (int i = 0; i < NC; i++) rd_same("R1", "count", cnt_a(i), 32'h0);
        irq_chk("R1", 1'b0);

        // R2 map: count window not writable, unmapped reads, slot 0 selector
        wr(cnt_a(1), 32'h1234);
        rd_same("R2", "count write ignored", cnt_a(1), 32'h0);
        rd_same("R2", "unmapped", 8'h10, 32'h0);
        rd_same("R2", "unaligned", 8'h21, 32'h0);
        wr(ctl_a(0), cw(8'hAB, 8'h12, 1'b0, 1'b0));
        rd_same("R2", "ctrl0 readback", ctl_a(0), 32'h0012_0000);
        wr(ctl_a(2), cw(8'h5A, 8'h00, 1'b0, 1'b1));
        rd_same("R2", "ctrl2 readback", ctl_a(2), 32'h5A00_0002);

        // R3 cycle counting sweep
        for (int n = 1; n <= 12; n++) begin
            wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b0));
            wr(ctl_a(0), cw(8'h0, 8'h0, 1'b1, 1'b1));
            idle(n);
            wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b1));
            rd_same("R3", "cycles", cnt_a(0), 32'(n));
        end

        // R4 clear sequence on the cycle slot
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b1));
        rd_same("R4", "clr 1->1 no clear", cnt_a(0), 32'd12);
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b0));
        rd_same("R4", "clr 0 no clear", cnt_a(0), 32'd12);
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b1));
        rd_same("R4", "clr 0->1 clears", cnt_a(0), 32'd0);

        // R6 preload
        wr(ctl_a(0), cw(8'h0, 8'h00, 1'b0, 1'b0));
        wr(ctl_a(0), cw(8'h0, 8'hF0, 1'b1, 1'b1));
        idle(5);
        wr(ctl_a(0), cw(8'h0, 8'hF0, 1'b0, 1'b1));
        rd_same("R6", "preloaded cycles", cnt_a(0), 32'hF005);
        rd_same("R6", "ctrl0 cp", ctl_a(0), 32'h00F0_0002);

        // start the cycle slot from 0
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b0));
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b1, 1'b1));

        // R7 sweep of all event codes
        wr(ctl_a(1), cw(8'h00, 8'h0, 1'b1, 1'b0));
        wr(ctl_a(2), cw(8'h37, 8'h0, 1'b1, 1'b0));
        wr(ctl_a(3), cw(8'hFF, 8'h0, 1'b1, 1'b0));
        e2 = 0; e3 = 0;
        for (int c = 0; c < 256; c++) begin
            rep[c] = (c % 3) + 1;
            for (int k = 0; k < rep[c]; k++) pulse(8'(c));
            if (c == 8'h37) e2 += rep[c];
            if (c == 8'hFF) e3 += rep[c];
        end
        rd_same("R7", "sel 0 never counts", cnt_a(1), 32'h0);
        rd_same("R7", "sel 0x37", cnt_a(2), 32'(e2));
        rd_same("R7", "sel 0xFF", cnt_a(3), 32'(e3));

        // R7 shared code, enable gating
        wr(ctl_a(1), cw(8'h21, 8'h0, 1'b1, 1'b0));
        wr(ctl_a(2), cw(8'h21, 8'h0, 1'b0, 1'b0));
        wr(ctl_a(3), cw(8'h21, 8'h0, 1'b1, 1'b0));
        for (int k = 0; k < 5; k++) pulse(8'h21);
        for (int k = 0; k < 3; k++) pulse(8'h22);
        rd_same("R7", "shared code slot1", cnt_a(1), 32'd5);
        rd_same("R7", "disabled slot2", cnt_a(2), 32'd0);
        rd_same("R7", "shared code slot3", cnt_a(3), 32'd5);

        // R5 event slot clear
        rd_same("R5", "clr reads 1", ctl_a(1), 32'h2100_0006);
        wr(ctl_a(1), cw(8'h21, 8'h0, 1'b1, 1'b1));
        rd_same("R5", "clr 1 keeps", cnt_a(1), 32'd5);
        wr(ctl_a(1), cw(8'h21, 8'h0, 1'b1, 1'b0));
        rd_same("R5", "clr 0 clears", cnt_a(1), 32'd0);

        // R11 halting through slot 0 enable
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b0, 1'b1));
        for (int k = 0; k < 4; k++) pulse(8'h21);
        rd_same("R11", "slot1 halted", cnt_a(1), 32'd0);
        rd_same("R11", "slot3 halted", cnt_a(3), 32'd5);
        wr(ctl_a(0), cw(8'h0, 8'h0, 1'b1, 1'b1));
        for (int k = 0; k < 2; k++) pulse(8'h21);
        rd_same("R11", "slot3 resumed", cnt_a(3), 32'd7);

        // R10 event overflow, R6 preload on an event slot
        wr(ctl_a(1), cw(8'h10, 8'hFF, 1'b1, 1'b0));
        rd_same("R6", "event preload", cnt_a(1), 32'hFF00);
        for (int k = 0; k < 255; k++) pulse(8'h10);
        rd_same("R10", "at max", cnt_a(1), 32'hFFFF);
        rd_same("R10", "no ovf yet", ctl_a(1), 32'h10FF_0006);
        pulse(8'h10);
        rd_both("R10", "after wrap", cnt_a(1), 32'h0, 32'hFFFF);
        rd_same("R10", "ovf set", ctl_a(1), 32'h10FF_0007);
        irq_chk("R10", 1'b0);
        for (int k = 0; k < 3; k++) pulse(8'h10);
        rd_both("R10", "post wrap", cnt_a(1), 32'd3, 32'hFFFF);
        rd_same("R10", "ovf sticky", ctl_a(1), 32'h10FF_0007);
        wr(ctl_a(1), cw(8'h10, 8'h00, 1'b1, 1'b0));
        rd_same("R5", "ovf cleared", ctl_a(1), 32'h1000_0006);
        rd_same("R5", "count cleared", cnt_a(1), 32'd0);

        // R8 / R9 cycle slot overflow
        wr(ctl_a(3), cw(8'h21, 8'h0, 1'b1, 1'b0));
        wr(ctl_a(0), cw(8'h0, 8'h00, 1'b0, 1'b0));
        wr(ctl_a(0), cw(8'h0, 8'hFF, 1'b1, 1'b1));
        idle(254);
        rd_same("R8", "cycles before wrap", cnt_a(0), 32'hFFFE);
        irq_chk("R9", 1'b0);
        pulse(8'h21);
        idle(1);
        rd_same("R8", "cycle wrapped", cnt_a(0), 32'h0);
        rd_same("R8", "ctrl0 ovf", ctl_a(0), 32'h00FF_0007);
        rd_same("R8", "slot3 counted", cnt_a(3), 32'd1);
        irq_chk("R9", 1'b1);
        for (int k = 0; k < 3; k++) pulse(8'h21);
        idle(10);
        rd_same("R8", "slot3 frozen", cnt_a(3), 32'd1);
        rd_same("R8", "cycle frozen", cnt_a(0), 32'h0);
        wr(ctl_a(0), cw(8'h0, 8'hFF, 1'b0, 1'b1));
        irq_chk("R9", 1'b0);
        rd_same("R9", "ovf kept", ctl_a(0), 32'h00FF_0003);
        wr(ctl_a(0), cw(8'h0, 8'hFF, 1'b1, 1'b1));
        irq_chk("R9", 1'b1);
        wr(ctl_a(0), cw(8'h0, 8'h00, 1'b1, 1'b0));
        wr(ctl_a(0), cw(8'h0, 8'h00, 1'b1, 1'b1));
        irq_chk("R9", 1'b0);
        rd_same("R4", "reload clears ovf", ctl_a(0), 32'h0000_0006);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule